// File: doc/BRIEF.md
# Packed Shift and Rotate Unit

A purely combinational shifter for a 64-bit packed operand. The word is split into four 16-bit lanes, two 32-bit lanes or one 64-bit lane, and every lane is shifted or rotated on its own by the same unsigned count. No bit ever moves from one lane into another. Four operations are offered: logical right shift, logical left shift, arithmetic right shift and rotate right.

Beside the data result, the unit produces a 32-bit status word with a negative flag and a zero flag for each lane of the result. The flag positions depend on the lane size. A neighbouring status register decodes this word, so the positions are fixed.

The unit has no state. Its result follows its inputs within the same cycle, so it can sit directly in an execute stage.

Top module: `pk_shift_unit`

## Requirements
- R1: With op_i = 0, each lane is shifted right logically by amount_i, zeros enter at the top of that lane, and no bit crosses a lane boundary.
- R2: With op_i = 1, each lane is shifted left logically by amount_i, zeros enter at the bottom of that lane, and no bit crosses a lane boundary.
- R3: With op_i = 2, each lane is shifted right arithmetically, and the bits that enter are copies of that lane's own most significant bit.
- R4: With op_i = 3, each lane is rotated right by amount_i modulo the lane width, and bits leaving the bottom of a lane enter the top of the same lane.
- R5: When amount_i (an unsigned 8-bit count) is equal to or larger than the lane width:
  - a logical shift (op_i 0 or 1) gives a zero lane;
  - an arithmetic shift gives a lane filled with its sign bit.
- R6: A count of zero returns the operand unchanged for every operation and lane size.
- R7: Lane size select: lane_sel_i = 0 selects 16-bit lanes, 1 selects 32-bit lanes, and 2 or 3 select one 64-bit lane.
- R8: For lane i of width W, flags_o bit (i+1)*W/2-1 is the lane's result MSB (negative) and bit (i+1)*W/2-2 is set when the lane's result is zero. All other flag bits are 0. This gives bits 8i+7/8i+6 for 16-bit lanes, 16i+15/16i+14 for 32-bit lanes, and 31/30 for the 64-bit lane.
- R9: The unit is combinational: result_o and flags_o reflect the current inputs with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_i | input | 64 | Packed operand |
| amount_i | input | 8 | Unsigned shift or rotate count, shared by all lanes |
| lane_sel_i | input | 2 | Lane size: 0 = 16-bit, 1 = 32-bit, 2 or 3 = 64-bit |
| op_i | input | 2 | 0 logical right, 1 logical left, 2 arithmetic right, 3 rotate right |
| result_o | output | 64 | Shifted or rotated packed result |
| flags_o | output | 32 | Per-lane negative and zero flags |

## Verification
The assertions check several properties whenever the inputs change:
- a zero count passes the operand through unchanged;
- an oversized logical count clears the word;
- an arithmetic shift keeps the top sign bit;
- a rotate preserves the number of set bits;
- no flag bit is set outside the positions allowed for the selected lane size.

The exact per-lane bit placement, lane isolation at each boundary, the modulo behaviour of rotate counts and the value of every flag can only be shown by the bench's scenarios. The bench sweeps every count from 0 to 70 for each lane size and operation and compares the outputs against a bit-by-bit reference model.

// File: rtl/pk_shift_unit.sv
module pk_shift_unit #(
  parameter int DATA_W   = 64,
  parameter int CNT_W    = 8,
  parameter int MIN_LANE = 16
) (
  input  logic [DATA_W-1:0]   opnd_i,
  input  logic [CNT_W-1:0]    amount_i,
  input  logic [1:0]          lane_sel_i,
  input  logic [1:0]          op_i,
  output logic [DATA_W-1:0]   result_o,
  output logic [DATA_W/2-1:0] flags_o
);
  localparam int NSZ = $clog2(DATA_W / MIN_LANE) + 1;
  localparam logic [1:0] TOP_SZ = 2'(NSZ - 1);

  logic [NSZ-1:0][DATA_W-1:0]   res_sz;
  logic [NSZ-1:0][DATA_W/2-1:0] flg_sz;
  logic [NSZ-1:0][DATA_W/2-1:0] flg_mask;
  logic [1:0]                   sz_idx;

  for (genvar g = 0; g < NSZ; g++) begin : g_sz
    localparam int W  = MIN_LANE << g;
    localparam int NL = DATA_W / W;
    localparam int SW = $clog2(W);
    for (genvar l = 0; l < NL; l++) begin : g_ln
      logic [W-1:0]   x, y;
      logic [2*W-1:0] dbl;
      logic           big;
      logic [SW-1:0]  rc;

      assign x   = opnd_i[l*W +: W];
      assign big = amount_i >= CNT_W'(W);
      assign rc  = amount_i[SW-1:0];
      assign dbl = {x, x} >> rc;

      always_comb begin
        case (op_i)
          2'd0:    y = big ? '0 : x >> amount_i;
          2'd1:    y = big ? '0 : x << amount_i;
          2'd2:    y = big ? {W{x[W-1]}} : $unsigned($signed(x) >>> amount_i);
          default: y = dbl[W-1:0];
        endcase
      end

      assign res_sz[g][l*W +: W]                  = y;
      assign flg_sz[g][(l+1)*(W/2)-1]             = y[W-1];
      assign flg_sz[g][(l+1)*(W/2)-2]             = ~|y;
      assign flg_sz[g][l*(W/2) +: (W/2-2)]        = '0;
      assign flg_mask[g][(l+1)*(W/2)-1 -: 2]      = 2'b11;
      assign flg_mask[g][l*(W/2) +: (W/2-2)]      = '0;
    end
  end

  assign sz_idx   = (lane_sel_i > TOP_SZ) ? TOP_SZ : lane_sel_i;
  assign result_o = res_sz[sz_idx];
  assign flags_o  = flg_sz[sz_idx];

  always_comb begin
    if (amount_i == '0)
      a_r6_zero_count_passes: assert (result_o == opnd_i)
        else $error("zero count altered operand");
    if (op_i[1] == 1'b0 && amount_i >= CNT_W'(DATA_W))
      a_r5_logical_oversize_clears: assert (result_o == '0)
        else $error("oversized logical shift left bits");
    if (op_i == 2'd2)
      a_r3_top_sign_kept: assert (result_o[DATA_W-1] == opnd_i[DATA_W-1])
        else $error("arithmetic shift lost sign");
    if (op_i == 2'd3)
      a_r4_rotate_keeps_ones: assert ($countones(result_o) == $countones(opnd_i))
        else $error("rotate changed population");
    a_r8_flags_in_place: assert ((flags_o & ~flg_mask[sz_idx]) == '0)
      else $error("flag outside its slot");
  end
endmodule

// File: tb/sim_pk_shift_unit.sv
`timescale 1ns/1ps
module sim_pk_shift_unit;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [63:0] x_r;
  logic [7:0]  a_r;
  logic [1:0]  s_r, o_r;
  logic [63:0] res;
  logic [31:0] flg;
  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  pk_shift_unit u0 (
    .opnd_i(x_r), .amount_i(a_r), .lane_sel_i(s_r), .op_i(o_r),
    .result_o(res), .flags_o(flg)
  );

  function automatic logic [95:0] ref_op(logic [63:0] x, int amt, int sz, int op);
    int w = (sz == 0) ? 16 : (sz == 1) ? 32 : 64;
    logic [63:0] r = '0;
    logic [31:0] f = '0;
    for (int l = 0; l < 64 / w; l++) begin
      int b = l * w;
      bit z = 1'b1;
      for (int j = 0; j < w; j++) begin
        int s = j + amt;
        case (op)
          0:       r[b+j] = (s < w) ? x[b+s] : 1'b0;
          1:       r[b+j] = (j >= amt) ? x[b+j-amt] : 1'b0;
          2:       r[b+j] = (s < w) ? x[b+s] : x[b+w-1];
          default: r[b+j] = x[b + ((j + amt) % w)];
        endcase
        if (r[b+j]) z = 1'b0;
      end
      f[(l+1)*(w/2)-1] = r[b+w-1];
      f[(l+1)*(w/2)-2] = z;
    end
    return {f, r};
  endfunction

  function automatic string tag_of(int amt, int sz, int op);
    int w = (sz == 0) ? 16 : (sz == 1) ? 32 : 64;
    if (amt == 0) return "R6";
    if (op != 3 && amt >= w) return "R5";
    case (op)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic check(logic [63:0] x, int amt, int sz, int op, string note);
    logic [95:0] e;
    @(posedge clk);
    x_r = x; a_r = 8'(amt); s_r = 2'(sz); o_r = 2'(op);
    #2;
    e = ref_op(x, amt, sz, op);
    total++;
    if (res !== e[63:0]) begin
      bad++;
      $display("FAIL %s%s result x=%h amt=%0d sz=%0d op=%0d got=%h exp=%h",
               tag_of(amt, sz, op), note, x, amt, sz, op, res, e[63:0]);
    end
    total++;
    if (flg !== e[95:64]) begin
      bad++;
      $display("FAIL R8%s flags x=%h amt=%0d sz=%0d op=%0d got=%h exp=%h",
               note, x, amt, sz, op, flg, e[95:64]);
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      bad++;
      $display("FAIL R9 watchdog expired got=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    x_r = '0; a_r = '0; s_r = '0; o_r = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    #2;
    // reset-state check: all-zero inputs give zero data and all 16-bit zero flags
    total++;
    if (res !== 64'h0 || flg !== 32'h4040_4040) begin
      bad++;
      $display("FAIL R8 reset state got=%h/%h exp=%h/%h", res, flg, 64'h0, 32'h4040_4040);
    end
    // R9: change inputs mid-cycle, no edge, output follows
    @(negedge clk);
    x_r = 64'h0000_0000_0000_00F0; a_r = 8'd4; s_r = 2'd0; o_r = 2'd0;
    #1;
    total++;
    if (res !== 64'h0000_0000_0000_000F) begin
      bad++;
      $display("FAIL R9 combinational got=%h exp=%h", res, 64'h0000_0000_0000_000F);
    end
    // directed lane-boundary cases (R1 R2 R3 R4 R7)
    check(64'h8000_0000_0000_0001, 1, 0, 3, " R7 rot16");
    check(64'h8000_0000_0000_0001, 1, 1, 3, " R7 rot32");
    check(64'h8000_0000_0000_0001, 1, 2, 3, " R7 rot64");
    check(64'h8000_0000_0000_0001, 1, 3, 3, " R7 sel3");
    check(64'h8001_8001_8001_8001, 1, 0, 0, " R1 boundary");
    check(64'h8001_8001_8001_8001, 1, 0, 1, " R2 boundary");
    check(64'h8000_7FFF_8000_7FFF, 15, 0, 2, " R3 sign");
    check(64'h8000_0000_7FFF_FFFF, 40, 1, 2, " R5 sign fill");
    check(64'hFFFF_FFFF_FFFF_FFFF, 64, 2, 0, " R5 full");
    check(64'hFFFF_FFFF_FFFF_FFFF, 255, 2, 1, " R5 max count");
    check(64'h1234_5678_9ABC_DEF0, 16, 0, 3, " R4 modulo");
    check(64'h1234_5678_9ABC_DEF0, 200, 2, 3, " R4 modulo64");
    // sweep counts 0..70 for each size and op
    for (int sz = 0; sz < 4; sz++)
      for (int op = 0; op < 4; op++)
        for (int amt = 0; amt <= 70; amt++)
          check({$urandom, $urandom}, amt, sz, op, " sweep");
    // random counts over the full range
    for (int k = 0; k < 2000; k++)
      check({$urandom, $urandom}, int'($urandom % 256), int'($urandom % 4),
            int'($urandom % 4), " random");
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule